// File: doc/BRIEF.md
# Grouped Completion Interrupt Controller

This block decides when a host controller interrupts its CPU about finished transfer descriptors. Each of three schedule classes (isochronous, periodic-interrupt and asynchronous) delivers a vector of per-descriptor done flags. Software programs two masks for each class:

- An all-of mask. Its group fires once every selected descriptor has finished.
- An any-of mask. Its group fires as soon as one selected descriptor finishes.

A fourth source records frame-timer ticks.

Each source has a sticky status bit and an enable bit. The interrupt line is the OR of the enabled status bits. A latency register can defer delivery by a whole number of frame ticks, so that several completions can share one interrupt. Software clears status by writing ones. The block has a simple register write port and a combinational read port.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: For each class, when its all-of mask is nonzero and every done bit under that mask is 1, the class status bit is set on the next clock edge. Status bit 0 is isochronous, bit 1 is interrupt-list and bit 2 is asynchronous.
- R2: An all-of mask of zero never sets a status bit, whatever the done bits are.
- R3: For each class, when any done bit under its any-of mask is 1, the class status bit is set on the next clock edge.
- R4: A status bit is set only when its class condition changes from false to true. A condition that stays true does not set the bit again after it has been cleared.
- R5: The status register is at address 6. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R6: Each cycle with the frame tick high sets status bit 3 on the next clock edge.
- R7: With latency 0, the irq output equals the OR over bits 3:0 of status AND enable. The enable register is at address 7, bits 3:0.
- R8: The latency register is at address 8. With latency N > 0, irq stays low until N frame ticks have occurred while an enabled status bit was pending. Ticks are counted from the cycle after the status first becomes pending. When nothing is pending, the tick count restarts.
- R9: The masks, enable and latency registers read back what was written, truncated to their widths.
  - Class c has its all-of mask at address 2c and its any-of mask at address 2c+1.
  - Addresses 9 to 15 read as 0.
- R10: Done bits of one class never set the status bit of another class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| iso_done | input | NDESC | Done flags of isochronous descriptors |
| intr_done | input | NDESC | Done flags of interrupt-list descriptors |
| asyn_done | input | NDESC | Done flags of asynchronous descriptors |
| sof_tick | input | 1 | One-cycle frame timer tick |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench sweeps every mask against every done pattern, for both group types on a 4-descriptor build, and checks that the other classes stay quiet. This catches an all-of group that fires on an empty mask or on a partial match, and status leaking between classes. It clears status while a condition is held true, to catch a level-sensitive design that would set the bit again at once. It also issues a tick and a clear of the tick bit in the same cycle, to catch a design where the clear wins. Latency values 0 to 5 are stepped tick by tick, which exposes an off-by-one that fires one tick early or late. The same steps catch a counter that does not restart after status is cleared.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int NCLS    = 3;
  localparam int NSRC    = NCLS + 1;
  localparam int SRC_SOF = NCLS;
  localparam int AW      = 4;
  localparam int DW      = 32;

  localparam logic [AW-1:0] A_STAT = 4'd6;
  localparam logic [AW-1:0] A_EN   = 4'd7;
  localparam logic [AW-1:0] A_LAT  = 4'd8;

  function automatic logic [AW-1:0] all_addr(input int cls);
    return AW'(2 * cls);
  endfunction

  function automatic logic [AW-1:0] any_addr(input int cls);
    return AW'(2 * cls + 1);
  endfunction
endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/cic_group_eval.sv
module cic_group_eval #(
  parameter int NDESC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NDESC-1:0] done,
  input  logic [NDESC-1:0] all_mask,
  input  logic [NDESC-1:0] any_mask,
  output logic             hit
);
  logic all_ok, any_ok, cond_now;
  logic prev_q, prev_d;

  always_comb begin
    all_ok   = (|all_mask) && ((done & all_mask) == all_mask);
    any_ok   = |(done & any_mask);
    cond_now = all_ok || any_ok;
    prev_d   = cond_now;
    hit      = cond_now && !prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/cic_status.sv
module cic_status #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] status_q
);
  logic [NSRC-1:0] status_d;
  logic            stat_en;

  always_comb begin
    status_d = status_q;
    if (clr_we) status_d = status_d & ~clr_vec;
    status_d = status_d | set_vec;
    stat_en  = clr_we || (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= '0;
    else if (stat_en) status_q <= status_d;
  end
endmodule

// File: rtl/cic_latency.sv
module cic_latency #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic             sof_tick,
  input  logic [LAT_W-1:0] lat,
  output logic             deliver
);
  logic [LAT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pending)
      cnt_d = '0;
    else if (sof_tick && (cnt_q < lat))
      cnt_d = cnt_q + LAT_W'(1);
    deliver = pending && (cnt_q >= lat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
  import cic_pkg::*;
#(
  parameter int NDESC = 32,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NDESC-1:0] iso_done,
  input  logic [NDESC-1:0] intr_done,
  input  logic [NDESC-1:0] asyn_done,
  input  logic             sof_tick,
  output logic             irq
);
  logic rst_n_s;

  logic [NCLS-1:0][NDESC-1:0] done_arr;
  logic [NCLS-1:0][NDESC-1:0] all_q, any_q;
  logic [NCLS-1:0]            all_we, any_we;
  logic [NSRC-1:0]            set_vec, status_q, en_q;
  logic [LAT_W-1:0]           lat_q;
  logic                       en_we, lat_we, stat_we;
  logic                       pending, deliver;

  cic_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign done_arr[0] = iso_done;
  assign done_arr[1] = intr_done;
  assign done_arr[2] = asyn_done;

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      all_we[c] = reg_wr && (reg_addr == all_addr(c));
      any_we[c] = reg_wr && (reg_addr == any_addr(c));
    end
    en_we   = reg_wr && (reg_addr == A_EN);
    lat_we  = reg_wr && (reg_addr == A_LAT);
    stat_we = reg_wr && (reg_addr == A_STAT);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      all_q <= '0;
      any_q <= '0;
    end else begin
      for (int c = 0; c < NCLS; c++) begin
        if (all_we[c]) all_q[c] <= reg_wdata[NDESC-1:0];
        if (any_we[c]) any_q[c] <= reg_wdata[NDESC-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   en_q <= '0;
    else if (en_we) en_q <= reg_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    lat_q <= '0;
    else if (lat_we) lat_q <= reg_wdata[LAT_W-1:0];
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    cic_group_eval #(.NDESC(NDESC)) u_eval (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .done     (done_arr[g]),
      .all_mask (all_q[g]),
      .any_mask (any_q[g]),
      .hit      (set_vec[g])
    );
  end
  assign set_vec[SRC_SOF] = sof_tick;

  cic_status #(.NSRC(NSRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_vec  (set_vec),
    .clr_we   (stat_we),
    .clr_vec  (reg_wdata[NSRC-1:0]),
    .status_q (status_q)
  );

  assign pending = |(status_q & en_q);

  cic_latency #(.LAT_W(LAT_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pending  (pending),
    .sof_tick (sof_tick),
    .lat      (lat_q),
    .deliver  (deliver)
  );

  assign irq = deliver;

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (reg_addr == all_addr(c)) reg_rdata = DW'(all_q[c]);
      if (reg_addr == any_addr(c)) reg_rdata = DW'(any_q[c]);
    end
    if (reg_addr == A_STAT) reg_rdata = DW'(status_q);
    if (reg_addr == A_EN)   reg_rdata = DW'(en_q);
    if (reg_addr == A_LAT)  reg_rdata = DW'(lat_q);
  end
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int LAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             sof_tick,
  input logic             irq,
  input logic [3:0]       status,
  input logic [3:0]       enable,
  input logic [LAT_W-1:0] lat
);
  // R6
  p_tick_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sof_tick |=> status[3]);

  // R7
  p_irq_needs_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(status & enable)));

  // R7 and R8
  p_lat0_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat == '0) && (|(status & enable))) |-> irq);

  // R5
  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);

  // R8
  p_rise_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && !$past(reg_wr) && (lat != '0)) |-> $past(sof_tick));
endmodule

bind cmpl_irq_ctrl cic_checker #(.LAT_W(LAT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .sof_tick (sof_tick),
  .irq      (irq),
  .status   (status_q),
  .enable   (en_q),
  .lat      (lat_q)
);

// File: tb/cmpl_irq_ctrl_tb.sv
module cmpl_irq_ctrl_tb;
  localparam int ND = 4;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [3:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [ND-1:0] dn [3];
  logic          sof_tick;
  logic          irq;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  ended  = 1'b0;

  always #4 clk = ~clk;

  cmpl_irq_ctrl #(.NDESC(ND), .LAT_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .iso_done(dn[0]), .intr_done(dn[1]), .asyn_done(dn[2]),
    .sof_tick(sof_tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic set_done(input int c, input logic [ND-1:0] v);
    @(negedge clk);
    dn[c] = v;
  endtask

  task automatic tick();
    @(negedge clk); sof_tick = 1'b1;
    @(negedge clk); sof_tick = 1'b0;
  endtask

  task automatic zero_done();
    @(negedge clk);
    for (int c = 0; c < 3; c++) dn[c] = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [ND-1:0] m, d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; sof_tick = 1'b0;
    for (int c = 0; c < 3; c++) dn[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(4'd6, v); chk("R5 reset status", v, 0);
    rd(4'd7, v); chk("R7 reset enable", v, 0);
    chk("R7 reset irq", {31'd0, irq}, 0);

    // R9 readback
    for (int a = 0; a < 6; a++) begin
      wr(4'(a), 32'hFFFF_FFF0 | 32'(a + 5));
      rd(4'(a), v); chk("R9 mask readback", v, (32'(a + 5)) & 32'hF);
    end
    wr(4'd7, 32'hFFFF_FFFA); rd(4'd7, v); chk("R9 enable readback", v, 32'hA);
    wr(4'd8, 32'h1234_5678); rd(4'd8, v); chk("R9 latency readback", v, 32'h78);
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), v); chk("R9 unused address", v, 0);
    end
    for (int a = 0; a < 9; a++) wr(4'(a), 0);

    // R1 R2 R3 R10 sweep
    for (int c = 0; c < 3; c++) begin
      for (int mode = 0; mode < 2; mode++) begin
        for (int mi = 0; mi < 16; mi++) begin
          m = ND'(mi);
          zero_done();
          wr(4'(2 * c + mode), 32'(m));
          for (int di = 0; di < 16; di++) begin
            d = ND'(di);
            zero_done();
            wr(4'd6, 32'hF);
            set_done(c, d);
            @(negedge clk);
            rd(4'd6, v);
            if (mode == 0)
              chk((m == 0) ? "R2 empty all-of" : "R1 all-of", v,
                  ((m != 0) && ((d & m) == m)) ? (32'd1 << c) : 0);
            else
              chk("R3 any-of R10 isolation", v, ((d & m) != 0) ? (32'd1 << c) : 0);
          end
          zero_done();
          wr(4'(2 * c + mode), 0);
        end
      end
    end

    // R4 held condition does not re-set
    wr(4'd1, 1); wr(4'd6, 32'hF);
    set_done(0, 4'b0001); @(negedge clk);
    rd(4'd6, v); chk("R4 first set", v, 1);
    wr(4'd6, 1); @(negedge clk);
    rd(4'd6, v); chk("R4 no re-set while held", v, 0);
    set_done(0, 0); set_done(0, 4'b0001); @(negedge clk);
    rd(4'd6, v); chk("R4 new rise sets", v, 1);

    // R5 write zero keeps, set beats clear
    wr(4'd6, 0); rd(4'd6, v); chk("R5 write zero no effect", v, 1);
    @(negedge clk);
    sof_tick = 1'b1; reg_wr = 1'b1; reg_addr = 4'd6; reg_wdata = 32'h8;
    @(negedge clk);
    sof_tick = 1'b0; reg_wr = 1'b0;
    rd(4'd6, v); chk("R5 R6 set wins over clear", v, 32'h9);
    tick(); rd(4'd6, v); chk("R6 tick sets bit3", v, 32'h9);
    zero_done(); wr(4'd1, 0);

    // R7 enable sweep over every status pattern
    wr(4'd8, 0);
    wr(4'd1, 1); wr(4'd3, 1); wr(4'd5, 1);
    for (int s = 0; s < 16; s++) begin
      wr(4'd7, 0);
      wr(4'd6, 32'hF);
      @(negedge clk);
      for (int c = 0; c < 3; c++) dn[c] = s[c] ? ND'(1) : '0;
      sof_tick = s[3];
      @(negedge clk);
      sof_tick = 1'b0;
      for (int c = 0; c < 3; c++) dn[c] = '0;
      rd(4'd6, v); chk("R7 status pattern", v, 32'(s));
      for (int e = 0; e < 16; e++) begin
        wr(4'd7, 32'(e));
        chk("R7 irq = OR(status & enable)", {31'd0, irq}, ((s & e) != 0) ? 1 : 0);
      end
    end
    zero_done();

    // R8 latency
    for (int n = 0; n < 6; n++) begin
      wr(4'd7, 0); wr(4'd6, 32'hF);
      wr(4'd8, 32'(n)); wr(4'd7, 1);
      set_done(0, 0); set_done(0, 1); @(negedge clk);
      chk("R8 before ticks", {31'd0, irq}, (n == 0) ? 1 : 0);
      for (int k = 1; k <= n + 1; k++) begin
        tick();
        chk("R8 after tick", {31'd0, irq}, (k >= n) ? 1 : 0);
      end
      wr(4'd6, 1);
      chk("R8 clear drops irq", {31'd0, irq}, 0);
      set_done(0, 0); set_done(0, 1); @(negedge clk);
      chk("R8 count restarts", {31'd0, irq}, (n == 0) ? 1 : 0);
    end

    finish_run();
  end
endmodule